// File: doc/BRIEF.md
# Oscillator Fault Monitor with Clock Failover

This block watches two external crystal clock sources, one low-frequency and one high-frequency, and an internal digitally controlled oscillator. It counts rising edges of each crystal clock over a repeating window of 256 reference-clock cycles. When an enabled crystal shows fewer rising edges than a programmable minimum in one window, that crystal's fault flag is raised. The internal oscillator is flagged when its frequency-control word sits at either end of its range. Each per-source flag clears by itself once its source behaves again. All flags start out raised after reset.

Any per-source flag sets a sticky summary flag. Software can clear the summary flag with a pulse, but the clear has no effect while a source is still flagged. While the summary flag is set, the main-clock select output is forced to the internal oscillator. When the interrupt enable is set, the summary flag also raises a non-maskable interrupt request. The enable drops by itself when the interrupt is acknowledged. The glitch-free clock multiplexer is outside the block, and only the select value is produced here.

Top module: `osc_fault_monitor`

## Requirements
- R1: While reset is held, all three source flags and the summary flag read 1, `nmi_req` reads 0 and `mclk_sel` reads 2'b00.
- R2: An enabled crystal that shows fewer than `edge_min` rising edges in a 256-cycle window has its flag set at the end of that window, and its flag changes at no other time while it stays enabled.
- R3: An enabled crystal that shows at least `edge_min` rising edges in a window has its flag cleared at the end of that window.
- R4: A crystal flag reads 0 one cycle after that crystal's enable is low, whatever its clock is doing.
- R5: The internal-oscillator flag is 1 one cycle after `dco_ctrl` is all zeros or all ones, and 0 one cycle after any other value.
- R6: The summary flag is 1 in the cycle after any source flag is 1. A `flag_clr` pulse clears it only when no source flag is set.
- R7: Once set, the summary flag stays 1 after all source flags have cleared, until `flag_clr` is pulsed.
- R8: `mclk_sel` is 2'b00 (internal oscillator) while the summary flag is 1. Otherwise it equals `mclk_sel_req` (01 low-frequency crystal, 10 high-frequency crystal).
- R9: `nmi_req` is the summary flag ANDed with the interrupt enable. `nmi_ie_set` sets the enable. `nmi_ack` clears it in the next cycle and wins over a simultaneous set.
- R10: With `edge_min` equal to 0, no crystal flag is raised, even when the crystal clock is stuck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also used for the 256-cycle window |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_en | input | 1 | Low-frequency crystal enabled |
| hf_en | input | 1 | High-frequency crystal enabled |
| lf_clk_in | input | 1 | Low-frequency crystal clock, sampled |
| hf_clk_in | input | 1 | High-frequency crystal clock, sampled |
| dco_ctrl | input | 5 | Internal oscillator frequency-control word |
| edge_min | input | 9 | Minimum rising edges per window for a healthy crystal |
| flag_clr | input | 1 | Software clear pulse for the summary flag |
| nmi_ie_set | input | 1 | Sets the interrupt enable |
| nmi_ack | input | 1 | Interrupt taken; clears the enable |
| mclk_sel_req | input | 2 | Requested main-clock source |
| lf_fault | output | 1 | Low-frequency crystal fault flag |
| hf_fault | output | 1 | High-frequency crystal fault flag |
| dco_fault | output | 1 | Internal oscillator boundary fault flag |
| fault_any | output | 1 | Sticky summary fault flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| mclk_sel | output | 2 | Main-clock select after failover |

## Verification
The assertions assume that each crystal clock input toggles no faster than once every two reference cycles, so that the synchronizer sees every edge. They also assume that `edge_min` and the enables are held steady across a window when a flag is expected to settle. The bench meets these conditions by using crystal half-periods of at least two reference cycles. It changes settings only at a falling edge and then waits three whole windows before it compares any flag. Control pulses last exactly one cycle and are driven away from the active edge.

// File: rtl/osc_fault_pkg.sv
// Shared encodings for the oscillator fault monitor.
// Assumes: two crystal sources, indexed 0 = low-frequency, 1 = high-frequency.
package osc_fault_pkg;
    localparam int NUM_XTAL = 2;
    localparam int XTAL_LF  = 0;
    localparam int XTAL_HF  = 1;

    typedef enum logic [1:0] {
        SEL_DCO = 2'b00,
        SEL_LF  = 2'b01,
        SEL_HF  = 2'b10,
        SEL_RSV = 2'b11
    } mclk_sel_e;
endpackage

// File: rtl/osc_window_timer.sv
// Free-running window counter. It pulses win_end in the last cycle of every
// WIN_LEN-cycle window.
// Assumes: WIN_LEN is a power of two, so the counter wraps naturally.
module osc_window_timer #(
    parameter int WIN_LEN = 256,
    localparam int WIN_W  = $clog2(WIN_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    logic [WIN_W-1:0] win_cnt;

    // Advance the window position every reference cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) win_cnt <= '0;
        else        win_cnt <= win_cnt + 1'b1;
    end

    assign win_end = (win_cnt == WIN_W'(WIN_LEN - 1));
endmodule

// File: rtl/osc_edge_monitor.sv
// Activity monitor for one crystal clock. It synchronizes the sampled clock,
// counts its rising edges per window and updates the fault flag at window end.
// Assumes: the monitored clock toggles at most once every two reference cycles.
module osc_edge_monitor #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             osc_in,
    input  logic             win_end,
    input  logic [CNT_W-1:0] edge_min,
    output logic             fault
);
    logic             sync1, sync2, sync3;
    logic             rise;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] cnt_next;

    // Two-stage synchronizer plus a delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= osc_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign rise     = sync2 & ~sync3;
    assign cnt_next = (rise && edge_cnt != '1) ? edge_cnt + 1'b1 : edge_cnt;

    // Count rising edges and restart the count at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_cnt <= '0;
        else if (win_end) edge_cnt <= '0;
        else              edge_cnt <= cnt_next;
    end

    // Fault flag: set on reset, cleared while disabled, otherwise judged at window end.
    always_ff @(posedge clk) begin
        if (!rst_n)       fault <= 1'b1;
        else if (!en)     fault <= 1'b0;
        else if (win_end) fault <= (cnt_next < edge_min);
    end

    // R4: a disabled crystal never reports a fault.
    a_r4_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fault);
    // R2: while enabled, the flag moves only at a window boundary.
    a_r2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !win_end) |=> $stable(fault));
endmodule

// File: rtl/osc_fault_combiner.sv
// Sticky summary flag and interrupt enable. Any source fault sets the summary
// flag. A software clear works only when no source is faulty.
// Assumes: flag_clr, ie_set and ack are single-cycle pulses.
module osc_fault_combiner #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_fault,
    input  logic               flag_clr,
    input  logic               ie_set,
    input  logic               ack,
    output logic               fault_any,
    output logic               nmi_req
);
    logic any_src;
    logic nmi_ie;

    assign any_src = |src_fault;

    // Summary flag: set on reset or on any source fault, else cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        fault_any <= 1'b1;
        else if (any_src)  fault_any <= 1'b1;
        else if (flag_clr) fault_any <= 1'b0;
    end

    // Interrupt enable: the acknowledge takes priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)      nmi_ie <= 1'b0;
        else if (ack)    nmi_ie <= 1'b0;
        else if (ie_set) nmi_ie <= 1'b1;
    end

    assign nmi_req = fault_any & nmi_ie;

    // R6: any source fault sets the summary flag.
    a_r6_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> fault_any);
    // R7: without a clear, the summary flag holds.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_any && !flag_clr) |=> fault_any);
    // R9: taking the interrupt drops the request.
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !nmi_req);
endmodule

// File: rtl/osc_fault_monitor.sv
// Top level of the oscillator fault monitor. Two crystal activity monitors and a
// boundary check on the internal oscillator feed a sticky summary flag. The
// summary flag forces the main-clock select to the internal oscillator.
// Assumes: clk is the reference clock, and crystal clocks arrive as sampled levels.
module osc_fault_monitor
    import osc_fault_pkg::*;
#(
    parameter int WIN_LEN = 256,
    parameter int CTRL_W  = 5,
    localparam int CNT_W  = $clog2(WIN_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lf_en,
    input  logic              hf_en,
    input  logic              lf_clk_in,
    input  logic              hf_clk_in,
    input  logic [CTRL_W-1:0] dco_ctrl,
    input  logic [CNT_W-1:0]  edge_min,
    input  logic              flag_clr,
    input  logic              nmi_ie_set,
    input  logic              nmi_ack,
    input  logic [1:0]        mclk_sel_req,
    output logic              lf_fault,
    output logic              hf_fault,
    output logic              dco_fault,
    output logic              fault_any,
    output logic              nmi_req,
    output logic [1:0]        mclk_sel
);
    logic                win_end;
    logic [NUM_XTAL-1:0] xtal_en;
    logic [NUM_XTAL-1:0] xtal_clk;
    logic [NUM_XTAL-1:0] xtal_fault;
    logic                dco_at_edge;

    assign xtal_en[XTAL_LF]  = lf_en;
    assign xtal_en[XTAL_HF]  = hf_en;
    assign xtal_clk[XTAL_LF] = lf_clk_in;
    assign xtal_clk[XTAL_HF] = hf_clk_in;

    osc_window_timer #(.WIN_LEN(WIN_LEN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar g = 0; g < NUM_XTAL; g++) begin : g_xtal
        osc_edge_monitor #(.CNT_W(CNT_W)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (xtal_en[g]),
            .osc_in   (xtal_clk[g]),
            .win_end  (win_end),
            .edge_min (edge_min),
            .fault    (xtal_fault[g])
        );
    end

    assign lf_fault    = xtal_fault[XTAL_LF];
    assign hf_fault    = xtal_fault[XTAL_HF];
    assign dco_at_edge = (dco_ctrl == '0) || (dco_ctrl == '1);

    // Internal-oscillator flag: registered boundary detection, set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dco_fault <= 1'b1;
        else        dco_fault <= dco_at_edge;
    end

    osc_fault_combiner #(.NUM_SRC(NUM_XTAL + 1)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_fault ({dco_fault, xtal_fault}),
        .flag_clr  (flag_clr),
        .ie_set    (nmi_ie_set),
        .ack       (nmi_ack),
        .fault_any (fault_any),
        .nmi_req   (nmi_req)
    );

    assign mclk_sel = fault_any ? SEL_DCO : mclk_sel_req;

    // R8: failover holds the main clock on the internal oscillator.
    a_r8_failover: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |-> (mclk_sel == SEL_DCO));
    // R5: a boundary control word raises the internal-oscillator flag.
    a_r5_dco_edge: assert property (@(posedge clk) disable iff (!rst_n)
        dco_at_edge |=> dco_fault);
    // R1: during reset the select points at the internal oscillator.
    always_comb begin
        if (!rst_n && fault_any) a_r1_reset_sel: assert (mclk_sel == SEL_DCO);
    end
endmodule

// File: tb/tb_osc_fault_monitor.sv
`timescale 1ns/1ps
module tb_osc_fault_monitor;
    localparam int WIN = 256;

    typedef struct packed {
        logic [7:0] lf_half;
        logic [7:0] hf_half;
        logic       lf_en;
        logic       hf_en;
        logic [4:0] ctrl;
        logic [8:0] emin;
        logic [2:0] exp_f;   // {dco, hf, lf}
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd4,  8'd2,  1'b1, 1'b1, 5'd12, 9'd8, 3'b000},
        '{8'd0,  8'd2,  1'b1, 1'b1, 5'd12, 9'd8, 3'b001},
        '{8'd4,  8'd64, 1'b1, 1'b1, 5'd12, 9'd8, 3'b010},
        '{8'd0,  8'd0,  1'b0, 1'b0, 5'd12, 9'd8, 3'b000},
        '{8'd4,  8'd2,  1'b1, 1'b1, 5'd0,  9'd8, 3'b100},
        '{8'd4,  8'd2,  1'b1, 1'b1, 5'd31, 9'd8, 3'b100},
        '{8'd0,  8'd0,  1'b1, 1'b1, 5'd12, 9'd0, 3'b000},
        '{8'd64, 8'd4,  1'b1, 1'b1, 5'd12, 9'd8, 3'b001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_en = 1'b0, hf_en = 1'b0;
    logic       lf_clk_in = 1'b0, hf_clk_in = 1'b0;
    logic [4:0] dco_ctrl = 5'd12;
    logic [8:0] edge_min = 9'd8;
    logic       flag_clr = 1'b0, nmi_ie_set = 1'b0, nmi_ack = 1'b0;
    logic [1:0] mclk_sel_req = 2'b10;
    logic       lf_fault, hf_fault, dco_fault, fault_any, nmi_req;
    logic [1:0] mclk_sel;

    logic [7:0] lf_half = 8'd0, hf_half = 8'd0;
    int         n_checks = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    osc_fault_monitor dut (
        .clk(clk), .rst_n(rst_n), .lf_en(lf_en), .hf_en(hf_en),
        .lf_clk_in(lf_clk_in), .hf_clk_in(hf_clk_in), .dco_ctrl(dco_ctrl),
        .edge_min(edge_min), .flag_clr(flag_clr), .nmi_ie_set(nmi_ie_set),
        .nmi_ack(nmi_ack), .mclk_sel_req(mclk_sel_req), .lf_fault(lf_fault),
        .hf_fault(hf_fault), .dco_fault(dco_fault), .fault_any(fault_any),
        .nmi_req(nmi_req), .mclk_sel(mclk_sel)
    );

    // Crystal clock generators; a half-period of 0 means the clock is stuck low.
    initial begin
        int lc = 0;
        int hc = 0;
        forever begin
            @(negedge clk);
            if (lf_half == 0) begin lf_clk_in = 1'b0; lc = 0; end
            else if (lc >= lf_half - 1) begin lf_clk_in = ~lf_clk_in; lc = 0; end
            else lc++;
            if (hf_half == 0) begin hf_clk_in = 1'b0; hc = 0; end
            else if (hc >= hf_half - 1) begin hf_clk_in = ~hf_clk_in; hc = 0; end
            else hc++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; wait_cyc(1); flag_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        // R1: reset values, sampled while reset is still held.
        chk("R1 lf_fault", lf_fault, 1);
        chk("R1 hf_fault", hf_fault, 1);
        chk("R1 dco_fault", dco_fault, 1);
        chk("R1 fault_any", fault_any, 1);
        chk("R1 nmi_req", nmi_req, 0);
        chk("R1 mclk_sel", mclk_sel, 0);

        lf_half = 8'd4; hf_half = 8'd2; lf_en = 1'b1; hf_en = 1'b1;
        rst_n = 1'b1;
        wait_cyc(100);
        // R2: a healthy crystal keeps its reset flag until the window ends.
        chk("R2 lf flag held mid-window", lf_fault, 1);

        for (int i = 0; i < 8; i++) begin
            lf_half  = VECS[i].lf_half;
            hf_half  = VECS[i].hf_half;
            lf_en    = VECS[i].lf_en;
            hf_en    = VECS[i].hf_en;
            dco_ctrl = VECS[i].ctrl;
            edge_min = VECS[i].emin;
            wait_cyc(3 * WIN + 10);
            // R2/R3/R4/R5/R10 per-source flags after settling.
            chk($sformatf("R2_R3 lf vec%0d", i), lf_fault, VECS[i].exp_f[0]);
            chk($sformatf("R2_R3 hf vec%0d", i), hf_fault, VECS[i].exp_f[1]);
            chk($sformatf("R5 dco vec%0d", i), dco_fault, VECS[i].exp_f[2]);
            pulse_clr();
            wait_cyc(2);
            // R6: the clear is effective only without an active source fault.
            chk($sformatf("R6 any vec%0d", i), fault_any, int'(|VECS[i].exp_f));
            // R8: select follows the request only when no fault remains.
            chk($sformatf("R8 sel vec%0d", i), mclk_sel, (|VECS[i].exp_f) ? 0 : 2);
        end

        // R4: dropping the enable clears a raised crystal flag within one cycle.
        lf_half = 8'd0; lf_en = 1'b1;
        wait_cyc(3 * WIN);
        chk("R2 stuck lf flagged", lf_fault, 1);
        lf_en = 1'b0;
        wait_cyc(1);
        chk("R4 disable clears", lf_fault, 0);

        // R7: the summary flag stays set until software clears it.
        wait_cyc(5);
        chk("R7 sticky", fault_any, 1);
        chk("R8 forced sel", mclk_sel, 0);
        pulse_clr();
        wait_cyc(1);
        chk("R7 cleared by software", fault_any, 0);
        chk("R8 follows request", mclk_sel, 2);

        // R9: interrupt enable and acknowledge.
        nmi_ie_set = 1'b1; wait_cyc(1); nmi_ie_set = 1'b0;
        chk("R9 no request without fault", nmi_req, 0);
        dco_ctrl = 5'd31;
        wait_cyc(3);
        chk("R5 dco top boundary", dco_fault, 1);
        chk("R9 request raised", nmi_req, 1);
        nmi_ack = 1'b1; wait_cyc(1); nmi_ack = 1'b0;
        chk("R9 ack clears", nmi_req, 0);
        nmi_ie_set = 1'b1; nmi_ack = 1'b1; wait_cyc(1);
        nmi_ie_set = 1'b0; nmi_ack = 1'b0;
        chk("R9 ack wins", nmi_req, 0);
        nmi_ie_set = 1'b1; wait_cyc(1); nmi_ie_set = 1'b0;
        chk("R9 re-enable", nmi_req, 1);

        // R6: a clear with a source still faulty leaves the summary set.
        pulse_clr();
        wait_cyc(1);
        chk("R6 clear ignored while faulty", fault_any, 1);
        dco_ctrl = 5'd12;
        wait_cyc(2);
        chk("R5 dco recovers", dco_fault, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule